// File: doc/BRIEF.md
# Address-Masked Target Traffic Counter

This block observes request traffic that a root complex sends toward device memory windows (PCIe BAR apertures) and CXL-attached memory ranges, and accumulates five event counts: qualified read requests, qualified write requests, bytes carried by those reads, bytes carried by those writes, and elapsed clock cycles. Software divides the byte and request counts by the cycle count to derive bandwidth and request rate.

Every cycle the upstream fabric may present one transaction. It carries its direction, its length in bytes, its target address, the index of the root port it is headed to, and a flag that tells CXL traffic apart from BAR traffic. A transaction is counted only when it qualifies. With the address filter disabled, only BAR traffic qualifies, and only when the bit of a per-port enable mask that matches its target port is set. With the address filter enabled, the port mask is bypassed, and both BAR and CXL traffic qualify by a masked comparison of the address against a programmed base.

Configuration uses a simple write strobe with a 2-bit register select. Counters are read through a combinational select mux.

Top module: `tgt_traffic_counter`

## Requirements
- R1: After reset all four traffic counters read zero, the port mask is all ones and the address filter is disabled, so BAR traffic to any port is counted.
- R2: A qualified read raises the read request count (rdSel 0) by one and the read byte count (rdSel 2) by txnLen, both at the same clock edge.
- R3: A qualified write raises the write request count (rdSel 1) by one and the write byte count (rdSel 3) by txnLen, both at the same clock edge.
- R4: With the address filter disabled, BAR traffic is counted only if bit txnPort of the port mask (cfgSel 0, bits 7:0, bit i for port i) is set.
- R5: With the address filter disabled, CXL traffic (txnCxl=1) is never counted, whatever the port mask.
- R6: With the address filter enabled (cfgSel 1, bit 0), BAR and CXL traffic are counted exactly when (txnAddr AND mask) equals (base AND mask), where the base is cfgSel 2 and the mask is cfgSel 3. The port mask is ignored in this mode.
- R7: A base of 0x10000 with a mask of 0xFFF00 accepts 0x10000 and 0x100FF and rejects 0x0FFFF and 0x10100.
- R8: The cycle counter (rdSel 4) grows by one on every clock edge after reset.
- R9: A configuration write takes effect for transactions from the next cycle on. A transaction presented in the same cycle as the write is judged under the old settings.
- R10: While txnValid is low, no traffic counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 port mask, 1 filter enable, 2 base, 3 mask |
| cfgWdata | input | ADDR_W | Configuration write data |
| txnValid | input | 1 | Transaction present this cycle |
| txnWrite | input | 1 | 1 = write, 0 = read |
| txnLen | input | LEN_W | Transaction length in bytes |
| txnAddr | input | ADDR_W | Target address |
| txnPort | input | PORT_W | Target root port index |
| txnCxl | input | 1 | 1 = CXL traffic, 0 = BAR traffic |
| rdSel | input | 3 | Counter select: 0 rd req, 1 wr req, 2 rd bytes, 3 wr bytes, 4 cycles |
| rdData | output | CNT_W | Selected counter value |

## Verification
A configuration write and a transaction can occur in the same cycle. Qualification must then use the settings from before the write. The bench provokes this in two ways. First, it disables the address filter in the same cycle as a matching CXL read, and expects that read to be counted. Second, it sends another CXL read in the next cycle and expects that one to be dropped. Request and byte increments also coincide on every counted transaction, and the checks confirm that both moved after the same single edge.

// File: rtl/tgt_traffic_pkg.sv
package tgt_traffic_pkg;
  // Per-cycle strobes from qualification control to the counter datapath.
  typedef struct packed {
    logic countRd;
    logic countWr;
  } cntStrobe_t;

  // Readout select codes.
  localparam logic [2:0] SEL_RD_REQ   = 3'd0;
  localparam logic [2:0] SEL_WR_REQ   = 3'd1;
  localparam logic [2:0] SEL_RD_BYTES = 3'd2;
  localparam logic [2:0] SEL_WR_BYTES = 3'd3;
  localparam logic [2:0] SEL_CYCLES   = 3'd4;

  // Configuration select codes.
  localparam logic [1:0] CFG_PORT_MASK = 2'd0;
  localparam logic [1:0] CFG_FILT_EN   = 2'd1;
  localparam logic [1:0] CFG_BASE      = 2'd2;
  localparam logic [1:0] CFG_MASK      = 2'd3;
endpackage

// File: rtl/tgt_qual_ctrl.sv
module tgt_qual_ctrl
  import tgt_traffic_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 40,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              txnValid,
  input  logic              txnWrite,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [PORT_W-1:0] txnPort,
  input  logic              txnCxl,
  output cntStrobe_t        stb
);
  logic [NUM_PORTS-1:0] portMask;
  logic                 filtEn;
  logic [ADDR_W-1:0]    addrBase;
  logic [ADDR_W-1:0]    addrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portMask <= '1;
      filtEn   <= 1'b0;
      addrBase <= '0;
      addrMask <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        CFG_PORT_MASK: portMask <= cfgWdata[NUM_PORTS-1:0];
        CFG_FILT_EN:   filtEn   <= cfgWdata[0];
        CFG_BASE:      addrBase <= cfgWdata;
        default:       addrMask <= cfgWdata;
      endcase
    end
  end

  logic addrHit;
  logic portHit;
  logic qualified;

  always_comb begin
    addrHit   = (txnAddr & addrMask) == (addrBase & addrMask);
    portHit   = !txnCxl && portMask[txnPort];
    qualified = txnValid && (filtEn ? addrHit : portHit);
    stb.countRd = qualified && !txnWrite;
    stb.countWr = qualified && txnWrite;
  end
endmodule

// File: rtl/tgt_count_dpath.sv
module tgt_count_dpath
  import tgt_traffic_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       stb,
  input  logic [LEN_W-1:0] txnLen,
  input  logic [2:0]       rdSel,
  output logic [CNT_W-1:0] cntRdReq,
  output logic [CNT_W-1:0] cntWrReq,
  output logic [CNT_W-1:0] cntRdBytes,
  output logic [CNT_W-1:0] cntWrBytes,
  output logic [CNT_W-1:0] cntCycles,
  output logic [CNT_W-1:0] rdData
);
  localparam int PAD_W = CNT_W - LEN_W;
  logic [CNT_W-1:0] lenExt;
  assign lenExt = {{PAD_W{1'b0}}, txnLen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntRdReq   <= '0;
      cntWrReq   <= '0;
      cntRdBytes <= '0;
      cntWrBytes <= '0;
      cntCycles  <= '0;
    end else begin
      cntCycles <= cntCycles + 1'b1;
      if (stb.countRd) begin
        cntRdReq   <= cntRdReq + 1'b1;
        cntRdBytes <= cntRdBytes + lenExt;
      end
      if (stb.countWr) begin
        cntWrReq   <= cntWrReq + 1'b1;
        cntWrBytes <= cntWrBytes + lenExt;
      end
    end
  end

  always_comb begin
    case (rdSel)
      SEL_RD_REQ:   rdData = cntRdReq;
      SEL_WR_REQ:   rdData = cntWrReq;
      SEL_RD_BYTES: rdData = cntRdBytes;
      SEL_WR_BYTES: rdData = cntWrBytes;
      SEL_CYCLES:   rdData = cntCycles;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/tgt_traffic_counter.sv
module tgt_traffic_counter
  import tgt_traffic_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 40,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              txnValid,
  input  logic              txnWrite,
  input  logic [LEN_W-1:0]  txnLen,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [PORT_W-1:0] txnPort,
  input  logic              txnCxl,
  input  logic [2:0]        rdSel,
  output logic [CNT_W-1:0]  rdData
);
  cntStrobe_t       stb;
  logic [CNT_W-1:0] cntRdReq;
  logic [CNT_W-1:0] cntWrReq;
  logic [CNT_W-1:0] cntRdBytes;
  logic [CNT_W-1:0] cntWrBytes;
  logic [CNT_W-1:0] cntCycles;

  tgt_qual_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .txnValid(txnValid), .txnWrite(txnWrite), .txnAddr(txnAddr),
    .txnPort(txnPort), .txnCxl(txnCxl), .stb(stb)
  );

  tgt_count_dpath #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .txnLen(txnLen), .rdSel(rdSel),
    .cntRdReq(cntRdReq), .cntWrReq(cntWrReq), .cntRdBytes(cntRdBytes),
    .cntWrBytes(cntWrBytes), .cntCycles(cntCycles), .rdData(rdData)
  );
endmodule

// File: rtl/tgt_traffic_counter_chk.sv
module tgt_traffic_counter_chk
  import tgt_traffic_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [1:0]       cfgSel,
  input logic             cfgBit0,
  input logic             txnValid,
  input logic             txnCxl,
  input logic [LEN_W-1:0] txnLen,
  input cntStrobe_t       stb,
  input logic [CNT_W-1:0] cntRdReq,
  input logic [CNT_W-1:0] cntWrReq,
  input logic [CNT_W-1:0] cntRdBytes,
  input logic [CNT_W-1:0] cntWrBytes,
  input logic [CNT_W-1:0] cntCycles
);
  // Independent shadow of the filter enable, rebuilt from the config port.
  logic shadowEn;
  always_ff @(posedge clk) begin
    if (!rstN) shadowEn <= 1'b0;
    else if (cfgWe && cfgSel == CFG_FILT_EN) shadowEn <= cfgBit0;
  end

  a_r2_rd_pair: assert property (@(posedge clk) disable iff (!rstN)
    stb.countRd |=> (cntRdReq == $past(cntRdReq) + 1'b1) &&
                    (cntRdBytes == $past(cntRdBytes) + CNT_W'($past(txnLen))));

  a_r3_wr_pair: assert property (@(posedge clk) disable iff (!rstN)
    stb.countWr |=> (cntWrReq == $past(cntWrReq) + 1'b1) &&
                    (cntWrBytes == $past(cntWrBytes) + CNT_W'($past(txnLen))));

  a_r5_cxl_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && txnCxl && !shadowEn) |=>
      (cntRdReq == $past(cntRdReq)) && (cntWrReq == $past(cntWrReq)));

  a_r8_cycle_step: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> cntCycles == $past(cntCycles) + 1'b1);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !txnValid |=> $stable(cntRdReq) && $stable(cntWrReq) &&
                  $stable(cntRdBytes) && $stable(cntWrBytes));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.countRd && stb.countWr));
endmodule

bind tgt_traffic_counter tgt_traffic_counter_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgBit0(cfgWdata[0]),
  .txnValid(txnValid), .txnCxl(txnCxl), .txnLen(txnLen), .stb(stb),
  .cntRdReq(cntRdReq), .cntWrReq(cntWrReq), .cntRdBytes(cntRdBytes),
  .cntWrBytes(cntWrBytes), .cntCycles(cntCycles)
);

// File: tb/tgt_traffic_counter_tb.sv
`timescale 1ns/1ps
module tgt_traffic_counter_tb;
  localparam int ADDR_W = 40;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgSel = '0;
  logic [ADDR_W-1:0] cfgWdata = '0;
  logic              txnValid = 1'b0;
  logic              txnWrite = 1'b0;
  logic [LEN_W-1:0]  txnLen = '0;
  logic [ADDR_W-1:0] txnAddr = '0;
  logic [2:0]        txnPort = '0;
  logic              txnCxl = 1'b0;
  logic [2:0]        rdSel = '0;
  logic [CNT_W-1:0]  rdData;

  int errors = 0;
  int checks = 0;
  logic [CNT_W-1:0] expRd = 0, expWr = 0, expRdB = 0, expWrB = 0;

  always #10 clk = ~clk;

  tgt_traffic_counter u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .txnValid(txnValid), .txnWrite(txnWrite), .txnLen(txnLen), .txnAddr(txnAddr),
    .txnPort(txnPort), .txnCxl(txnCxl), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reads a counter at the current (non-edge) time.
  task automatic readCnt(input logic [2:0] sel, output logic [CNT_W-1:0] val);
    rdSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic checkAll(input string tag);
    logic [CNT_W-1:0] v;
    readCnt(3'd0, v); check({tag, " rd req"}, v, expRd);
    readCnt(3'd1, v); check({tag, " wr req"}, v, expWr);
    readCnt(3'd2, v); check({tag, " rd bytes"}, v, expRdB);
    readCnt(3'd3, v); check({tag, " wr bytes"}, v, expWrB);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [ADDR_W-1:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // One transaction; expected counts updated if it should qualify.
  task automatic send(input logic wr, input int len, input logic [ADDR_W-1:0] addr,
                      input logic [2:0] port, input logic cxl, input logic hit, input string tag);
    @(negedge clk);
    txnValid = 1'b1; txnWrite = wr; txnLen = LEN_W'(len);
    txnAddr = addr; txnPort = port; txnCxl = cxl;
    @(negedge clk);
    txnValid = 1'b0;
    if (hit) begin
      if (wr) begin expWr += 1; expWrB += CNT_W'(len); end
      else    begin expRd += 1; expRdB += CNT_W'(len); end
    end
    checkAll(tag);
  endtask

  task automatic t_reset;
    checkAll("R1 reset zero");
    send(1'b0, 64, 40'h0, 3'd7, 1'b0, 1'b1, "R1 default counts port 7");
    send(1'b1, 8, 40'h0, 3'd0, 1'b0, 1'b1, "R1 default counts port 0");
  endtask

  task automatic t_basic;
    send(1'b0, 200, 40'h1234, 3'd2, 1'b0, 1'b1, "R2 read len 200");
    send(1'b1, 16, 40'h5678, 3'd3, 1'b0, 1'b1, "R3 write len 16");
    send(1'b1, 4095, 40'h9, 3'd5, 1'b0, 1'b1, "R3 write max len");
  endtask

  task automatic t_cycles;
    logic [CNT_W-1:0] a, b;
    @(negedge clk);
    readCnt(3'd4, a);
    repeat (10) @(negedge clk);
    readCnt(3'd4, b);
    check("R8 cycle delta", b - a, 32'd10);
  endtask

  task automatic t_idle;
    @(negedge clk);
    txnValid = 1'b0; txnWrite = 1'b0; txnLen = 12'd99; txnPort = 3'd1;
    repeat (3) @(negedge clk);
    txnWrite = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R10 idle no count");
  endtask

  task automatic t_portMask;
    cfgWrite(2'd0, 40'h05);
    send(1'b0, 32, 40'h0, 3'd2, 1'b0, 1'b1, "R4 port 2 enabled");
    send(1'b0, 32, 40'h0, 3'd1, 1'b0, 1'b0, "R4 port 1 masked");
    send(1'b1, 32, 40'h0, 3'd7, 1'b0, 1'b0, "R4 port 7 masked");
    cfgWrite(2'd0, 40'hFF);
    send(1'b0, 48, 40'h10000, 3'd0, 1'b1, 1'b0, "R5 cxl read dropped");
    send(1'b1, 48, 40'h10000, 3'd4, 1'b1, 1'b0, "R5 cxl write dropped");
  endtask

  task automatic t_addrFilter;
    cfgWrite(2'd2, 40'h10000);
    cfgWrite(2'd3, 40'hFFF00);
    cfgWrite(2'd0, 40'h00);
    cfgWrite(2'd1, 40'h1);
    send(1'b0, 24, 40'h10080, 3'd0, 1'b1, 1'b1, "R6 cxl address hit");
    send(1'b1, 24, 40'h10040, 3'd1, 1'b0, 1'b1, "R6 bar hit bypasses port mask");
    send(1'b0, 24, 40'h20000, 3'd0, 1'b0, 1'b0, "R6 bar address miss");
    send(1'b0, 1, 40'h10000, 3'd0, 1'b0, 1'b1, "R7 low edge 0x10000");
    send(1'b0, 2, 40'h100FF, 3'd0, 1'b1, 1'b1, "R7 high edge 0x100FF");
    send(1'b0, 4, 40'h0FFFF, 3'd0, 1'b1, 1'b0, "R7 below 0x0FFFF");
    send(1'b1, 4, 40'h10100, 3'd0, 1'b0, 1'b0, "R7 above 0x10100");
  endtask

  task automatic t_sameCycle;
    // Filter disabled in the same cycle as a matching CXL read: old setting applies.
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'd1; cfgWdata = 40'h0;
    txnValid = 1'b1; txnWrite = 1'b0; txnLen = 12'd40; txnAddr = 40'h10010; txnCxl = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    expRd += 1; expRdB += 40;
    checkAll("R9 same cycle uses old config");
    txnValid = 1'b1;
    @(negedge clk);
    txnValid = 1'b0;
    checkAll("R9 next cycle uses new config");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_cycles();
    t_idle();
    t_portMask();
    t_addrFilter();
    t_sameCycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4ms;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule